// File: doc/BRIEF.md
# Repeating Alarm Unit

This unit holds four BCD alarm registers (seconds, minutes, hours and day of month) and compares them with the current time that a separate clock block supplies. When the time matches, it raises a single-cycle interrupt pulse. The comparison runs only when the clock block asserts its one-second tick strobe, so each qualifying second gives exactly one pulse.

The repeat rate is not chosen by a mode field. Bit 7 of every alarm register is a "don't care" mask, and the pattern of masks across the four registers sets the rate. The rates are monthly, daily, hourly, every minute and every second.

Software reaches the registers through a byte port: a two-bit register select, a write strobe and a combinational read path. A write whose BCD value is out of range is dropped, and the register keeps its old contents. A single enable input gates the interrupt.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset all four registers read 0x00, and no pulse is produced by any tick until at least one write has been accepted, even when the current time equals the reset contents.
- R2: An accepted write stores the whole byte, bit 7 included, and reads back unchanged. Register select codes are 0 = seconds, 1 = minutes, 2 = hours, 3 = date.
- R3: A write to seconds or minutes is accepted only if bits 6:0, decoded as tens (bits 6:4) times ten plus units (bits 3:0), give a value from 0 to 59.
- R4: A write to hours is accepted only if bits 5:0, decoded as tens times ten plus units, give a value from 0 to 23.
- R5: A write to date is rejected when bits 4:0 decode to zero, and is accepted otherwise.
- R6: With all four mask bits (bit 7) clear, a tick fires only if date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal the current time.
- R7: With only the date mask set, a tick fires when hours, minutes and seconds match, whatever the date.
- R8: With the date and hours masks set and the others clear, a tick fires when minutes and seconds match.
- R9: With the date, hours and minutes masks set and the seconds mask clear, a tick fires when seconds match.
- R10: Every other mask pattern, including the seconds mask alone, fires on every tick.
- R11: The pulse appears in the cycle after the tick and lasts one cycle.
- R12: With intEnable low, no tick produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for write and read |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Contents of the selected register |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current day of month, BCD |
| secTick | input | 1 | One-cycle strobe once per second |
| intEnable | input | 1 | Interrupt enable |
| alarmPulse | output | 1 | One-cycle alarm interrupt |

## Verification
The assertions assume that secTick is a one-cycle strobe that is never high on two cycles in a row. They also assume that the time inputs are steady in the cycle where the tick is sampled. The bench raises the tick for exactly one cycle, always returns it low before the next tick, and changes the time inputs only while the tick is low. The stored-value range checks hold only because every register update passes through the write validation, so the bench drives both legal and illegal BCD bytes through that path.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 4;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HOUR = 2'd2,
    SEL_DATE = 2'd3
  } fieldSel_e;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrDate;
    logic wrHour;
    logic wrMin;
    logic wrSec;
  } regStrobe_t;

  // tens nibble times ten plus units nibble
  function automatic logic [BYTE_W-1:0] bcdVal(input logic [BYTE_W-1:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  // bits of each field that take part in the time comparison
  function automatic logic [BYTE_W-1:0] cmpMask(input int idx);
    return (idx < 2) ? 8'h7F : 8'h3F;
  endfunction
endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NUM_FIELDS
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [W-1:0]     wrData,
  input  logic [SEL_W-1:0] rdSel,
  output logic [W-1:0]     rdData,
  input  logic [W-1:0]     curSec,
  input  logic [W-1:0]     curMin,
  input  logic [W-1:0]     curHour,
  input  logic [W-1:0]     curDate,
  output logic [N-1:0]     fieldMatch,
  output logic [N-1:0]     maskBits
);
  logic [N-1:0][W-1:0] regFile;
  logic [N-1:0][W-1:0] curVec;
  logic [N-1:0]        wrVec;

  assign wrVec  = strobe;          // index 0 = seconds .. 3 = date
  assign curVec = {curDate, curHour, curMin, curSec};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wrVec[i]) regFile[i] <= wrData;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_field
    assign fieldMatch[g] = ((regFile[g] ^ curVec[g]) & cmpMask(g)) == '0;
    assign maskBits[g]   = regFile[g][W-1];
  end

  assign rdData = regFile[rdSel];

  // Stored values stay within the ranges that the write check admits
  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    bcdVal(regFile[0] & 8'h7F) <= 8'd59);
  p_min_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    bcdVal(regFile[1] & 8'h7F) <= 8'd59);
  p_hour_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    bcdVal(regFile[2] & 8'h3F) <= 8'd23);
  p_date_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regFile[3] != $past(regFile[3])) |-> (bcdVal(regFile[3] & 8'h1F) != 8'd0));
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrVec == '0) |=> $stable(regFile));
endmodule

// File: rtl/alarm_control.sv
module alarm_control
  import alarm_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NUM_FIELDS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regAddr,
  input  logic [W-1:0]     wrData,
  output regStrobe_t       strobe,
  input  logic [N-1:0]     fieldMatch,
  input  logic [N-1:0]     maskBits,
  input  logic             secTick,
  input  logic             intEnable,
  output logic             alarmPulse
);
  logic       secMinOk, hourOk, dateOk;
  logic       armed;
  logic [4:0] modeOh;   // 0 month, 1 day, 2 hour, 3 minute, 4 second
  logic       timeHit, fire;

  // write validation
  assign secMinOk = bcdVal(wrData & 8'h7F) <= 8'd59;
  assign hourOk   = bcdVal(wrData & 8'h3F) <= 8'd23;
  assign dateOk   = bcdVal(wrData & 8'h1F) != 8'd0;

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (fieldSel_e'(regAddr))
        SEL_SEC:  strobe.wrSec  = secMinOk;
        SEL_MIN:  strobe.wrMin  = secMinOk;
        SEL_HOUR: strobe.wrHour = hourOk;
        SEL_DATE: strobe.wrDate = dateOk;
        default:  strobe = '0;
      endcase
    end
  end

  // repeat rate from the mask pattern {date, hour, min, sec}
  always_comb begin
    unique case (maskBits)
      4'b0000: modeOh = 5'b00001;
      4'b1000: modeOh = 5'b00010;
      4'b1100: modeOh = 5'b00100;
      4'b1110: modeOh = 5'b01000;
      default: modeOh = 5'b10000;
    endcase
  end

  always_comb begin
    unique case (1'b1)
      modeOh[0]: timeHit = &fieldMatch[3:0];
      modeOh[1]: timeHit = &fieldMatch[2:0];
      modeOh[2]: timeHit = &fieldMatch[1:0];
      modeOh[3]: timeHit = fieldMatch[0];
      default:   timeHit = 1'b1;
    endcase
  end

  assign fire = secTick && intEnable && armed && timeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      alarmPulse <= 1'b0;
    end else begin
      if (strobe != '0) armed <= 1'b1;
      alarmPulse <= fire;
    end
  end

  p_pulse_after_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> $past(secTick));
  p_no_pulse_unarmed_r1: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !alarmPulse);
  p_enable_gates_r12: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |=> !alarmPulse);
  p_mode_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(modeOh));
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] curSec,
  input  logic [BYTE_W-1:0] curMin,
  input  logic [BYTE_W-1:0] curHour,
  input  logic [BYTE_W-1:0] curDate,
  input  logic             secTick,
  input  logic             intEnable,
  output logic             alarmPulse
);
  regStrobe_t            strobe;
  logic [NUM_FIELDS-1:0] fieldMatch;
  logic [NUM_FIELDS-1:0] maskBits;

  alarm_control #(.W(BYTE_W), .N(NUM_FIELDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .strobe(strobe), .fieldMatch(fieldMatch), .maskBits(maskBits),
    .secTick(secTick), .intEnable(intEnable), .alarmPulse(alarmPulse)
  );

  alarm_datapath #(.W(BYTE_W), .N(NUM_FIELDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdSel(regAddr), .rdData(rdData),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .fieldMatch(fieldMatch), .maskBits(maskBits)
  );
endmodule

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] curSec = 8'h00, curMin = 8'h00, curHour = 8'h00, curDate = 8'h00;
  logic       secTick = 1'b0;
  logic       intEnable = 1'b1;
  logic       alarmPulse;

  int checks = 0;
  int fails  = 0;

  alarm_match_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDate(curDate), .secTick(secTick), .intEnable(intEnable),
    .alarmPulse(alarmPulse)
  );

  always #4 clk = ~clk;   // 125 MHz

  // {select, byte, accepted}
  localparam int NVEC = 16;
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd0, 8'h59, 1'b1}, {2'd0, 8'h60, 1'b0}, {2'd0, 8'hD9, 1'b1}, {2'd0, 8'h7F, 1'b0},
    {2'd1, 8'h00, 1'b1}, {2'd1, 8'h5A, 1'b0}, {2'd1, 8'h3A, 1'b1}, {2'd2, 8'h23, 1'b1},
    {2'd2, 8'h24, 1'b0}, {2'd2, 8'hE3, 1'b1}, {2'd2, 8'h1A, 1'b1}, {3'd3, 8'h00, 1'b0},
    {2'd3, 8'h80, 1'b0}, {2'd3, 8'h20, 1'b0}, {2'd3, 8'h31, 1'b1}, {2'd3, 8'h0A, 1'b1}
  };

  logic [7:0] model [4];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic setTime(input logic [7:0] dt, input logic [7:0] hr,
                         input logic [7:0] mi, input logic [7:0] se);
    @(negedge clk);
    curDate = dt; curHour = hr; curMin = mi; curSec = se;
  endtask

  task automatic setAlarm(input logic [7:0] dt, input logic [7:0] hr,
                          input logic [7:0] mi, input logic [7:0] se);
    writeReg(2'd3, dt); writeReg(2'd2, hr); writeReg(2'd1, mi); writeReg(2'd0, se);
  endtask

  // tick for one cycle; pulse is due one edge later and must then drop
  task automatic tickCheck(input logic exp, input string tag);
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    check({7'd0, alarmPulse}, {7'd0, exp}, tag);
    @(negedge clk);
    check({7'd0, alarmPulse}, 8'd0, {tag, " R11 width"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents and no pulse while unarmed (time 00 matches zeros)
    for (int i = 0; i < 4; i++) begin
      readReg(i[1:0], rd);
      check(rd, 8'h00, "R1 reset value");
      model[i] = 8'h00;
    end
    setTime(8'h00, 8'h00, 8'h00, 8'h00);
    tickCheck(1'b0, "R1 unarmed tick");

    // R2..R5: table of writes
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] a;
      logic [7:0] d;
      string tag;
      a = VEC[v][10:9];
      d = VEC[v][8:1];
      if (VEC[v][0]) model[a] = d;
      tag = (a == 2'd2) ? "R4" : (a == 2'd3) ? "R5" : "R3";
      writeReg(a, d);
      readReg(a, rd);
      check(rd, model[a], {tag, "/R2 write vector"});
    end

    // R6: monthly, no masks
    setAlarm(8'h12, 8'h08, 8'h15, 8'h30);
    setTime(8'h12, 8'h08, 8'h15, 8'h30);
    tickCheck(1'b1, "R6 full match");
    setTime(8'h13, 8'h08, 8'h15, 8'h30);
    tickCheck(1'b0, "R6 date differs");
    setTime(8'h12, 8'h08, 8'h15, 8'h31);
    tickCheck(1'b0, "R6 seconds differ");

    // R7: daily
    writeReg(2'd3, 8'h92);
    setTime(8'h05, 8'h08, 8'h15, 8'h30);
    tickCheck(1'b1, "R7 any date");
    setTime(8'h05, 8'h09, 8'h15, 8'h30);
    tickCheck(1'b0, "R7 hour differs");

    // R8: hourly
    writeReg(2'd2, 8'h88);
    setTime(8'h05, 8'h03, 8'h15, 8'h30);
    tickCheck(1'b1, "R8 any hour");
    setTime(8'h05, 8'h03, 8'h16, 8'h30);
    tickCheck(1'b0, "R8 minute differs");

    // R9: every minute
    writeReg(2'd1, 8'h95);
    setTime(8'h05, 8'h03, 8'h40, 8'h30);
    tickCheck(1'b1, "R9 any minute");
    setTime(8'h05, 8'h03, 8'h40, 8'h31);
    tickCheck(1'b0, "R9 seconds differ");

    // R10: all masks, then seconds mask alone
    writeReg(2'd0, 8'hB0);
    tickCheck(1'b1, "R10 all masked");
    setAlarm(8'h12, 8'h08, 8'h15, 8'hB0);
    setTime(8'h01, 8'h02, 8'h03, 8'h04);
    tickCheck(1'b1, "R10 seconds mask only");

    // R12: enable low
    @(negedge clk) intEnable = 1'b0;
    tickCheck(1'b0, "R12 disabled");
    @(negedge clk) intEnable = 1'b1;
    tickCheck(1'b1, "R12 re-enabled");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule